// File: doc/BRIEF.md
# Program-Step Data Capture Unit

This block snoops a signal-processing core while it runs its program. It keeps four independent channels. Each channel holds a 9-bit step number and a 2-bit tap code. When the program counter reaches a channel's step number, the channel copies one of four internal datapath words into its own capture register. The four datapath words are the multiplier product, the decibel converter result, the multiplier data operand and the multiplier coefficient operand.

Two channels are read by the control processor through a registered read port. They give it periodic snapshots of internal values, such as a level-meter reading. The other two channels are sent out on a single serial pin. That pin uses the audio input framing: the frame clock marks the halves of the frame and the bit clock shifts the bits. An external converter or a second processor can therefore receive the two words as an extra stereo stream.

All logic runs on one system clock. The frame and bit clocks are oversampled on that clock, and their falling edges are detected from the samples.

Top module: `pcap_unit`

## Requirements
- R1: Channel setup is written with `cfg_we_i`. Address 261 sets readback channel A, 262 sets readback channel B, 263 sets serial channel L and 264 sets serial channel R. `cfg_wdata_i[8:0]` is the step number and `cfg_wdata_i[10:9]` is the tap code. A write to any other address changes no channel.
- R2: After a synchronous reset every step number is 0, every tap code is 00, every capture register is zero, `sdo_o` is 0 and `rd_data_o` is 0.
- R3: On a clock edge where `pc_i` equals a channel's step number, that channel loads the selected tap. On any other edge it keeps its value.
- R4: The tap codes select as follows: 00 is `tap_mult_i`, 01 is `tap_db_i`, 10 is `tap_mdi_i` and 11 is `tap_mci_i`.
- R5: `rd_data_o` is registered and appears one clock after `rd_addr_i` is presented. Address 261 returns channel A's capture and 262 returns channel B's capture. Every other address returns zero.
- R6: While `frame_clk_i` is low, `sdo_o` carries channel L's word. While it is high, `sdo_o` carries channel R's word. The output changes only on falling edges of `bit_clk_i`. The bit slot that starts at a frame-clock edge is 0. The next slots carry the word MSB first, and the slots after the word are 0.
- R7: At the falling edge of the frame clock, the words for both halves of the new frame are taken from channels L and R. A capture made later in that frame appears only in the next frame.
- R8: Channels evaluate independently. Two channels with the same step number capture on the same edge, each through its own tap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 9 | Program counter of the core |
| tap_mult_i | input | DATA_W | Multiplier product |
| tap_db_i | input | DATA_W | Decibel converter output |
| tap_mdi_i | input | DATA_W | Multiplier data operand |
| tap_mci_i | input | DATA_W | Multiplier coefficient operand |
| cfg_we_i | input | 1 | Setup write strobe |
| cfg_addr_i | input | ADDR_W | Setup write address |
| cfg_wdata_i | input | 11 | Setup word: tap code in [10:9], step number in [8:0] |
| frame_clk_i | input | 1 | Frame clock; low for the left half, high for the right half |
| bit_clk_i | input | 1 | Serial bit clock |
| rd_addr_i | input | ADDR_W | Readback address |
| rd_data_o | output | DATA_W | Registered readback word |
| sdo_o | output | 1 | Serial capture output |

## Verification
The serializer assertions assume two things about the clock inputs. The frame clock changes only together with a falling edge of the bit clock. Each bit-clock level lasts at least two system clocks, so that no edge is lost in the oversampling. The bench follows both rules: it holds each bit-clock level for three system clocks or more, and it switches the frame clock only on the same cycle that it drops the bit clock. Program-counter and tap changes are driven at the opposite clock edge. As a result, each capture happens on exactly one known rising edge.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int STEP_W = 9;
  localparam int SEL_W  = 2;
  localparam int NUM_CH = 4;
  localparam int NUM_TAP = 1 << SEL_W;
  localparam int CFG_W  = STEP_W + SEL_W;

  typedef enum logic [SEL_W-1:0] {
    TAP_MULT = 2'd0,
    TAP_DB   = 2'd1,
    TAP_MDI  = 2'd2,
    TAP_MCI  = 2'd3
  } tap_sel_e;

  typedef struct packed {
    tap_sel_e            sel;
    logic [STEP_W-1:0]   step;
  } chan_cfg_t;
endpackage

// File: rtl/pcap_setup.sv
module pcap_setup import pcap_pkg::*; #(
  parameter int ADDR_W   = 9,
  parameter int CFG_BASE = 261
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CFG_W-1:0]         wdata_i,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o
);
  localparam logic [ADDR_W-1:0] ADDR_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] ADDR_HI = ADDR_W'(CFG_BASE + NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + g);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_o[g] <= '0;
      end else if (we_i && addr_i == MY_ADDR) begin
        cfg_o[g] <= chan_cfg_t'(wdata_i);
      end
    end
  end

  // R1: writes outside the channel window leave all setups untouched
  p_foreign_write_r1: assert property (@(posedge clk) disable iff (rst)
    (we_i && (addr_i < ADDR_LO || addr_i >= ADDR_HI)) |=> $stable(cfg_o));

  // R1: an idle write strobe leaves all setups untouched
  p_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/pcap_channel.sv
module pcap_channel import pcap_pkg::*; #(
  parameter int DATA_W = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [STEP_W-1:0]                 pc_i,
  input  chan_cfg_t                         cfg_i,
  input  logic [NUM_TAP-1:0][DATA_W-1:0]    taps_i,
  output logic [DATA_W-1:0]                 cap_o
);
  logic              match;
  logic [DATA_W-1:0] picked;

  always_comb begin
    match  = (pc_i == cfg_i.step);
    picked = taps_i[cfg_i.sel];
  end

  always_ff @(posedge clk) begin
    if (rst)        cap_o <= '0;
    else if (match) cap_o <= picked;
  end

  // R3: no step match, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (pc_i != cfg_i.step) |=> $stable(cap_o));

  // R4: tap code 00 takes the multiplier product
  p_tap_mult_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_i == cfg_i.step && cfg_i.sel == TAP_MULT) |=> cap_o == $past(taps_i[0]));

  // R4: tap code 01 takes the decibel result
  p_tap_db_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_i == cfg_i.step && cfg_i.sel == TAP_DB) |=> cap_o == $past(taps_i[1]));

  // R4: tap code 11 takes the coefficient operand
  p_tap_mci_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_i == cfg_i.step && cfg_i.sel == TAP_MCI) |=> cap_o == $past(taps_i[3]));
endmodule

// File: rtl/pcap_serializer.sv
module pcap_serializer #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_clk_i,
  input  logic              bit_clk_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              sdo_o
);
  logic              fc_r, fc_p, bc_r, bc_p;
  logic              bc_fall, fc_edge, left_start;
  logic [DATA_W-1:0] shreg, right_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      fc_r <= 1'b1;
      fc_p <= 1'b1;
      bc_r <= 1'b1;
      bc_p <= 1'b1;
    end else begin
      fc_r <= frame_clk_i;
      fc_p <= fc_r;
      bc_r <= bit_clk_i;
      bc_p <= bc_r;
    end
  end

  always_comb begin
    bc_fall    = bc_p & ~bc_r;
    fc_edge    = fc_p ^ fc_r;
    left_start = bc_fall & fc_edge & ~fc_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      right_word <= '0;
      sdo_o      <= 1'b0;
    end else if (bc_fall) begin
      if (fc_edge) begin
        sdo_o <= 1'b0;
        shreg <= fc_r ? right_word : left_i;
        if (!fc_r) right_word <= right_i;
      end else begin
        sdo_o <= shreg[DATA_W-1];
        shreg <= {shreg[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R6: the slot opened by a frame-clock edge is a zero bit
  p_gap_slot_r6: assert property (@(posedge clk) disable iff (rst)
    (bc_fall && fc_edge) |=> !sdo_o);

  // R6: the pin moves only on a bit-clock falling edge
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !bc_fall |=> $stable(sdo_o));

  // R7: the right-half word is frozen except at the left-half start
  p_frozen_right_r7: assert property (@(posedge clk) disable iff (rst)
    !left_start |=> $stable(right_word));
endmodule

// File: rtl/pcap_unit.sv
module pcap_unit import pcap_pkg::*; #(
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 9,
  parameter int CFG_BASE = 261
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] pc_i,
  input  logic [DATA_W-1:0] tap_mult_i,
  input  logic [DATA_W-1:0] tap_db_i,
  input  logic [DATA_W-1:0] tap_mdi_i,
  input  logic [DATA_W-1:0] tap_mci_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              frame_clk_i,
  input  logic              bit_clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sdo_o
);
  localparam int CH_RD_A = 0;
  localparam int CH_RD_B = 1;
  localparam int CH_SO_L = 2;
  localparam int CH_SO_R = 3;
  localparam logic [ADDR_W-1:0] RD_A_ADDR = ADDR_W'(CFG_BASE + CH_RD_A);
  localparam logic [ADDR_W-1:0] RD_B_ADDR = ADDR_W'(CFG_BASE + CH_RD_B);

  chan_cfg_t [NUM_CH-1:0]             cfg;
  logic [NUM_TAP-1:0][DATA_W-1:0]     taps;
  logic [NUM_CH-1:0][DATA_W-1:0]      cap;

  assign taps = {tap_mci_i, tap_mdi_i, tap_db_i, tap_mult_i};

  pcap_setup #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) i_setup (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pcap_channel #(.DATA_W(DATA_W)) i_chan (
      .clk    (clk),
      .rst    (rst),
      .pc_i   (pc_i),
      .cfg_i  (cfg[c]),
      .taps_i (taps),
      .cap_o  (cap[c])
    );
  end

  pcap_serializer #(.DATA_W(DATA_W)) i_ser (
    .clk         (clk),
    .rst         (rst),
    .frame_clk_i (frame_clk_i),
    .bit_clk_i   (bit_clk_i),
    .left_i      (cap[CH_SO_L]),
    .right_i     (cap[CH_SO_R]),
    .sdo_o       (sdo_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                         rd_data_o <= '0;
    else if (rd_addr_i == RD_A_ADDR) rd_data_o <= cap[CH_RD_A];
    else if (rd_addr_i == RD_B_ADDR) rd_data_o <= cap[CH_RD_B];
    else                             rd_data_o <= '0;
  end

  // R5: addresses other than the two readback slots return zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_i != RD_A_ADDR && rd_addr_i != RD_B_ADDR) |=> rd_data_o == '0);

  // R5: readback slot A follows channel A one clock later
  p_slot_a_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_i == RD_A_ADDR) |=> rd_data_o == $past(cap[CH_RD_A]));
endmodule

// File: tb/test_pcap_unit.sv
module test_pcap_unit;
  localparam int DW = 24;
  localparam logic [8:0] IDLE_PC = 9'd400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [8:0]    pc = IDLE_PC;
  logic [DW-1:0] t_mult, t_db, t_mdi, t_mci;
  logic          cfg_we = 1'b0;
  logic [8:0]    cfg_addr = '0;
  logic [10:0]   cfg_wdata = '0;
  logic          fclk = 1'b1;
  logic          bclk = 1'b1;
  logic [8:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          sdo;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] tapv(input int k, input logic [8:0] p);
    return {4'(k + 1), 11'(p), 9'(p ^ 9'h1A5)};
  endfunction

  assign t_mult = tapv(0, pc);
  assign t_db   = tapv(1, pc);
  assign t_mdi  = tapv(2, pc);
  assign t_mci  = tapv(3, pc);

  pcap_unit i_pcap_unit (
    .clk(clk), .rst(rst), .pc_i(pc),
    .tap_mult_i(t_mult), .tap_db_i(t_db), .tap_mdi_i(t_mdi), .tap_mci_i(t_mci),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .frame_clk_i(fclk), .bit_clk_i(bclk),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sdo_o(sdo)
  );

  // entries: {step[8:0], tap code[1:0], pc[8:0]}
  localparam logic [19:0] VEC [9] = '{
    {9'd5,   2'd0, 9'd5},
    {9'd5,   2'd1, 9'd6},
    {9'd6,   2'd1, 9'd6},
    {9'd6,   2'd2, 9'd6},
    {9'd100, 2'd3, 9'd100},
    {9'd511, 2'd3, 9'd511},
    {9'd0,   2'd2, 9'd0},
    {9'd0,   2'd0, 9'd1},
    {9'd300, 2'd1, 9'd300}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [8:0] a, input logic [10:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic step_pc(input logic [8:0] p);
    @(negedge clk); pc = p;
    @(negedge clk); pc = IDLE_PC;
  endtask

  task automatic rd(input logic [8:0] a, output logic [DW-1:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic run_half(input logic lvl, input bit mid, output logic [31:0] got);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); bclk = 1'b0; if (s == 0) fclk = lvl;
      if (mid && s == 10) begin
        wr_cfg(9'd264, {2'b00, 9'd30});
        step_pc(9'd30);
      end
      repeat (2) @(negedge clk);
      @(negedge clk); got[31-s] = sdo; bclk = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] v, prev;
    logic [31:0] lw, rw;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    chk("R2 sdo", {31'b0, sdo}, 32'h0);
    rd(9'd261, v); chk("R2 readback A", {8'h0, v}, 32'h0);
    rd(9'd262, v); chk("R2 readback B", {8'h0, v}, 32'h0);
    run_half(1'b0, 1'b0, lw);
    run_half(1'b1, 1'b0, rw);
    chk("R2 R6 empty left", lw, 32'h0);
    chk("R2 R6 empty right", rw, 32'h0);

    // R3 R4: table walk on readback channel A
    prev = '0;
    for (int i = 0; i < 9; i++) begin
      logic [8:0] st, p;
      logic [1:0] sl;
      {st, sl, p} = VEC[i];
      wr_cfg(9'd261, {sl, st});
      step_pc(p);
      if (p == st) prev = tapv(int'(sl), p);
      rd(9'd261, v);
      chk($sformatf("R3 R4 vector %0d", i), {8'h0, v}, {8'h0, prev});
    end

    // R1: writes outside the window are ignored
    wr_cfg(9'd260, {2'b00, 9'd7});
    wr_cfg(9'd265, {2'b00, 9'd7});
    step_pc(9'd7);
    rd(9'd261, v); chk("R1 foreign write", {8'h0, v}, {8'h0, prev});

    // R8: two channels on the same step
    wr_cfg(9'd261, {2'b10, 9'd50});
    wr_cfg(9'd262, {2'b11, 9'd50});
    step_pc(9'd50);
    rd(9'd261, v); chk("R8 channel A", {8'h0, v}, {8'h0, tapv(2, 9'd50)});
    rd(9'd262, v); chk("R8 channel B", {8'h0, v}, {8'h0, tapv(3, 9'd50)});

    // R5: unmapped readback addresses
    rd(9'd263, v); chk("R5 addr 263", {8'h0, v}, 32'h0);
    rd(9'd260, v); chk("R5 addr 260", {8'h0, v}, 32'h0);

    // R6 R7: serial halves and frame-boundary transfer
    wr_cfg(9'd263, {2'b01, 9'd20});
    wr_cfg(9'd264, {2'b11, 9'd21});
    step_pc(9'd20);
    step_pc(9'd21);
    run_half(1'b0, 1'b1, lw);
    run_half(1'b1, 1'b0, rw);
    chk("R6 left word", lw, {1'b0, tapv(1, 9'd20), 7'b0});
    chk("R7 right word frozen", rw, {1'b0, tapv(3, 9'd21), 7'b0});
    run_half(1'b0, 1'b0, lw);
    run_half(1'b1, 1'b0, rw);
    chk("R6 left word repeat", lw, {1'b0, tapv(1, 9'd20), 7'b0});
    chk("R7 right word next frame", rw, {1'b0, tapv(0, 9'd30), 7'b0});

    summary();
    $finish;
  end
endmodule